// File: doc/BRIEF.md
# Synchronous Exception Vector Classifier

This block sits beside an instruction decoder. On each cycle in which the decoder presents a 16-bit instruction word, it also supplies the current privilege mode, the overflow condition flag, and two flags from the execution side: one for a zero divisor and one for a failed bound check. From these it decides whether the instruction must raise a synchronous exception. If it must, the block also decides which exception vector number the sequencer should fetch.

The verdict is a valid flag plus an 8-bit vector number. It is registered, so it appears on the clock edge that follows the decode strobe. The opcode patterns fall into four groups: the two emulation groups, a small set of illegal words, sixteen software trap words and a list of privileged words. These patterns are fixed constants held in a package. The base vector of the software traps and the width of the vector output are parameters.

The two execution-side flags are taken as supplied; the block does no arithmetic of its own. When several causes are present at once, a fixed priority chooses one of them.

Top module: `exc_classifier`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `exc_valid` is 0 and `exc_vector` is 0.
- R2: A verdict appears one clock after the edge that samples `dec_valid` high. A cycle with `dec_valid` low gives `exc_valid` 0 and `exc_vector` 0 on the next cycle, whatever the other inputs are.
- R3: A word whose bits 15:12 are hex A gives vector 10. A word whose bits 15:12 are hex F gives vector 11. This holds in either mode and with any flags.
- R4: The words 4AFA, 4AFB and 4AFC (hex) give vector 4, in either mode and with any flags.
- R5: The privileged words are 4E70, 4E72 and 4E73 (hex). One of them with `supervisor` = 0 gives vector 8. With `supervisor` = 1, the same word raises nothing by itself.
- R6: A word of the form 4E4n (hex, n = 0..15) gives vector TRAP_BASE + n, which is 32 + n by default (trap 14 gives 46). This holds in either mode.
- R7: The word 4E76 (hex) gives vector 7 when `ovf_flag` = 1. With `ovf_flag` = 0 it raises nothing by itself.
- R8: `div_zero` = 1 gives vector 5 when no opcode cause of R3 to R7 applies.
- R9: `bound_fail` = 1 gives vector 6 when no other cause applies.
- R10: Causes are ranked from highest to lowest: emulation and illegal words, then privilege, then software trap, then overflow trap, then zero divisor, then bound check. Only the highest cause present is reported.
- R11: A strobed word with no applicable cause gives `exc_valid` 0 and `exc_vector` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode strobe; the other inputs are meaningful in this cycle |
| insn | input | 16 | Instruction word being decoded |
| supervisor | input | 1 | 1 = supervisor mode, 0 = user mode |
| ovf_flag | input | 1 | Overflow condition flag |
| div_zero | input | 1 | Divide instruction with a zero divisor |
| bound_fail | input | 1 | Bound check on the current instruction failed |
| exc_valid | output | 1 | An exception is raised by the word strobed one cycle earlier |
| exc_vector | output | VEC_W | Vector number of that exception, 0 when none |

## Verification
The bench builds the block with its default parameters: VEC_W = 8 and TRAP_BASE = 32. Because the opcode space is only 16 bits wide, every instruction word can be strobed once. Each word is paired with a mode-and-flag combination derived from the word itself, which covers all four groups together with their neighbouring non-matching words. A second sweep takes each special word and its near neighbours through all sixteen combinations of mode and flags. This reaches every priority conflict, and it also exercises the rule that privilege matters in user mode only. Idle cycles between the strobes check that nothing is reported without a strobe.

// File: rtl/exc_cls_pkg.sv
package exc_cls_pkg;

    localparam int INSN_W     = 16;
    localparam int TRAP_NUM_W = 4;

    // fixed vector numbers of the non-trap causes
    localparam int VEC_ILLEGAL = 4;
    localparam int VEC_DIVZERO = 5;
    localparam int VEC_BOUND   = 6;
    localparam int VEC_OVFTRAP = 7;
    localparam int VEC_PRIV    = 8;
    localparam int VEC_EMU_A   = 10;
    localparam int VEC_EMU_F   = 11;

    localparam logic [3:0]  EMU_A_NIB    = 4'hA;
    localparam logic [3:0]  EMU_F_NIB    = 4'hF;
    localparam logic [11:0] TRAP_PREFIX  = 12'h4E4;
    localparam logic [15:0] OVFTRAP_WORD = 16'h4E76;

    localparam int N_ILLEGAL = 3;
    localparam logic [15:0] ILLEGAL_WORDS [N_ILLEGAL] = '{16'h4AFA, 16'h4AFB, 16'h4AFC};

    localparam int N_PRIV = 3;
    localparam logic [15:0] PRIV_WORDS [N_PRIV] = '{16'h4E70, 16'h4E72, 16'h4E73};

    typedef struct packed {
        logic emu_a;
        logic emu_f;
        logic illegal;
        logic priv;
        logic trap;
        logic ovftrap;
    } op_hits_t;

    typedef enum logic [3:0] {
        CAUSE_NONE,
        CAUSE_EMU_A,
        CAUSE_EMU_F,
        CAUSE_ILLEGAL,
        CAUSE_PRIV,
        CAUSE_TRAP,
        CAUSE_OVFTRAP,
        CAUSE_DIVZERO,
        CAUSE_BOUND
    } cause_e;

    // vector of a fixed-number cause; traps are handled by the caller
    function automatic int fixed_vector(cause_e c);
        case (c)
            CAUSE_EMU_A:   return VEC_EMU_A;
            CAUSE_EMU_F:   return VEC_EMU_F;
            CAUSE_ILLEGAL: return VEC_ILLEGAL;
            CAUSE_PRIV:    return VEC_PRIV;
            CAUSE_OVFTRAP: return VEC_OVFTRAP;
            CAUSE_DIVZERO: return VEC_DIVZERO;
            CAUSE_BOUND:   return VEC_BOUND;
            default:       return 0;
        endcase
    endfunction

endpackage

// File: rtl/exc_op_match.sv
module exc_op_match
    import exc_cls_pkg::*;
(
    input  logic [INSN_W-1:0]     insn,
    output op_hits_t              hits,
    output logic [TRAP_NUM_W-1:0] trap_num
);

    logic [N_ILLEGAL-1:0] ill_eq;
    logic [N_PRIV-1:0]    priv_eq;

    for (genvar g = 0; g < N_ILLEGAL; g++) begin : g_ill
        assign ill_eq[g] = (insn == ILLEGAL_WORDS[g]);
    end

    for (genvar g = 0; g < N_PRIV; g++) begin : g_priv
        assign priv_eq[g] = (insn == PRIV_WORDS[g]);
    end

    always_comb begin
        hits.emu_a   = (insn[INSN_W-1 -: 4] == EMU_A_NIB);
        hits.emu_f   = (insn[INSN_W-1 -: 4] == EMU_F_NIB);
        hits.illegal = |ill_eq;
        hits.priv    = |priv_eq;
        hits.trap    = (insn[INSN_W-1:TRAP_NUM_W] == TRAP_PREFIX);
        hits.ovftrap = (insn == OVFTRAP_WORD);
    end

    assign trap_num = insn[TRAP_NUM_W-1:0];

endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_cls_pkg::*;
(
    input  op_hits_t hits,
    input  logic     supervisor,
    input  logic     ovf_flag,
    input  logic     div_zero,
    input  logic     bound_fail,
    output cause_e   cause
);

    always_comb begin
        if (hits.emu_a)                   cause = CAUSE_EMU_A;
        else if (hits.emu_f)              cause = CAUSE_EMU_F;
        else if (hits.illegal)            cause = CAUSE_ILLEGAL;
        else if (hits.priv && !supervisor) cause = CAUSE_PRIV;
        else if (hits.trap)               cause = CAUSE_TRAP;
        else if (hits.ovftrap && ovf_flag) cause = CAUSE_OVFTRAP;
        else if (div_zero)                cause = CAUSE_DIVZERO;
        else if (bound_fail)              cause = CAUSE_BOUND;
        else                              cause = CAUSE_NONE;
    end

endmodule

// File: rtl/exc_vec_map.sv
module exc_vec_map
    import exc_cls_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int TRAP_BASE = 32
) (
    input  cause_e                cause,
    input  logic [TRAP_NUM_W-1:0] trap_num,
    output logic                  hit,
    output logic [VEC_W-1:0]      vector
);

    localparam logic [VEC_W-1:0] TRAP_BASE_V = VEC_W'(TRAP_BASE);

    always_comb begin
        hit = (cause != CAUSE_NONE);
        if (cause == CAUSE_TRAP)
            vector = TRAP_BASE_V + VEC_W'(trap_num);
        else
            vector = VEC_W'(fixed_vector(cause));
    end

endmodule

// File: rtl/exc_classifier.sv
module exc_classifier
    import exc_cls_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int TRAP_BASE = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic [15:0]       insn,
    input  logic              supervisor,
    input  logic              ovf_flag,
    input  logic              div_zero,
    input  logic              bound_fail,
    output logic              exc_valid,
    output logic [VEC_W-1:0]  exc_vector
);

    op_hits_t              hits;
    logic [TRAP_NUM_W-1:0] trap_num;
    cause_e                cause;
    logic                  nxt_hit;
    logic [VEC_W-1:0]      nxt_vec;

    exc_op_match u_match (
        .insn     (insn),
        .hits     (hits),
        .trap_num (trap_num)
    );

    exc_prio_sel u_prio (
        .hits       (hits),
        .supervisor (supervisor),
        .ovf_flag   (ovf_flag),
        .div_zero   (div_zero),
        .bound_fail (bound_fail),
        .cause      (cause)
    );

    exc_vec_map #(.VEC_W(VEC_W), .TRAP_BASE(TRAP_BASE)) u_map (
        .cause    (cause),
        .trap_num (trap_num),
        .hit      (nxt_hit),
        .vector   (nxt_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid  <= 1'b0;
            exc_vector <= '0;
        end else if (dec_valid && nxt_hit) begin
            exc_valid  <= 1'b1;
            exc_vector <= nxt_vec;
        end else begin
            exc_valid  <= 1'b0;
            exc_vector <= '0;
        end
    end

    // ---------------- assertions ----------------
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> (!exc_valid && exc_vector == '0));

    assert_emu_a_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && insn[15:12] == 4'hA) |=> (exc_valid && exc_vector == VEC_W'(10)));

    assert_emu_f_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && insn[15:12] == 4'hF) |=> (exc_valid && exc_vector == VEC_W'(11)));

    assert_priv_user_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !supervisor && insn == 16'h4E73) |=> (exc_valid && exc_vector == VEC_W'(8)));

    assert_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && insn[15:4] == 12'h4E4)
        |=> (exc_valid && exc_vector == VEC_W'(TRAP_BASE) + VEC_W'($past(insn[3:0]))));

    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && insn == 16'h4E76 && !ovf_flag && !div_zero && !bound_fail)
        |=> !exc_valid);

    assert_valid_vec_R10: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ((exc_vector >= VEC_W'(4) && exc_vector <= VEC_W'(11) && exc_vector != VEC_W'(9))
                       || (exc_vector >= VEC_W'(TRAP_BASE) && exc_vector < VEC_W'(TRAP_BASE + 16))));

    assert_none_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> exc_vector == '0);

endmodule

// File: tb/test_exc_classifier.sv
`timescale 1ns/1ps
module test_exc_classifier;

    localparam int VEC_W     = 8;
    localparam int TRAP_BASE = 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             dec_valid;
    logic [15:0]      insn;
    logic             supervisor, ovf_flag, div_zero, bound_fail;
    logic             exc_valid;
    logic [VEC_W-1:0] exc_vector;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    exc_classifier #(.VEC_W(VEC_W), .TRAP_BASE(TRAP_BASE)) i_exc_classifier (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .insn(insn),
        .supervisor(supervisor), .ovf_flag(ovf_flag), .div_zero(div_zero),
        .bound_fail(bound_fail), .exc_valid(exc_valid), .exc_vector(exc_vector)
    );

    // expected {valid, vector} from the requirement text
    function automatic logic [8:0] model(input logic [15:0] w, input logic [3:0] st);
        logic sup, ovf, dz, bf;
        {sup, ovf, dz, bf} = st;
        if (w[15:12] == 4'hA)                                  return {1'b1, 8'd10};  // R3
        if (w[15:12] == 4'hF)                                  return {1'b1, 8'd11};  // R3
        if (w == 16'h4AFA || w == 16'h4AFB || w == 16'h4AFC)   return {1'b1, 8'd4};   // R4
        if (!sup && (w == 16'h4E70 || w == 16'h4E72 || w == 16'h4E73))
                                                               return {1'b1, 8'd8};   // R5
        if (w[15:4] == 12'h4E4)                                return {1'b1, 8'(TRAP_BASE + int'(w[3:0]))}; // R6
        if (w == 16'h4E76 && ovf)                              return {1'b1, 8'd7};   // R7
        if (dz)                                                return {1'b1, 8'd5};   // R8
        if (bf)                                                return {1'b1, 8'd6};   // R9
        return 9'd0;                                                                  // R11
    endfunction

    function automatic string req_of(input logic [8:0] e);
        if (!e[8]) return "R11";
        case (e[7:0])
            8'd10, 8'd11: return "R3";
            8'd4:         return "R4";
            8'd8:         return "R5";
            8'd7:         return "R7";
            8'd5:         return "R8";
            8'd6:         return "R9";
            default:      return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] exp, input logic [15:0] w, input logic [3:0] st);
        total++;
        if ({exc_valid, exc_vector} !== exp) begin
            bad++;
            $display("FAIL %s insn=%h state=%b actual v=%0b vec=%0d expected v=%0b vec=%0d",
                     req, w, st, exc_valid, exc_vector, exp[8], exp[7:0]);
        end
    endtask

    // strobe one word, check the registered verdict one cycle later (R2 timing)
    task automatic strobe(input logic [15:0] w, input logic [3:0] st, input string req_hint);
        logic [8:0] e;
        @(negedge clk);
        dec_valid = 1'b1;
        insn = w;
        {supervisor, ovf_flag, div_zero, bound_fail} = st;
        e = model(w, st);
        @(negedge clk);
        check(req_hint == "" ? req_of(e) : req_hint, e, w, st);
    endtask

    task automatic idle_check(input logic [15:0] w, input logic [3:0] st);
        @(negedge clk);
        dec_valid = 1'b0;
        insn = w;
        {supervisor, ovf_flag, div_zero, bound_fail} = st;
        @(negedge clk);
        check("R2", 9'd0, w, st);
    endtask

    initial begin
        rst = 1'b1; dec_valid = 1'b0; insn = 16'hA000;
        supervisor = 1'b0; ovf_flag = 1'b1; div_zero = 1'b1; bound_fail = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 9'd0, insn, 4'hF);          // during reset
        rst = 1'b0;
        dec_valid = 1'b0;
        @(negedge clk);
        check("R1", 9'd0, insn, 4'hF);          // first cycle after reset

        // idle strobes with causes present on the inputs (R2)
        idle_check(16'hA123, 4'hF);
        idle_check(16'h4E4E, 4'h0);
        idle_check(16'h4E73, 4'h0);

        // priority conflicts (R10)
        strobe(16'hF000, 4'b0111, "R10");  // emulation over flags
        strobe(16'h4E73, 4'b0111, "R10");  // privilege over flags
        strobe(16'h4E45, 4'b0011, "R10");  // trap over flags
        strobe(16'h4E76, 4'b0111, "R10");  // overflow trap over flags
        strobe(16'h1234, 4'b0011, "R10");  // zero divisor over bound

        // full opcode sweep, state derived from the word
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] w = 16'(i);
            strobe(w, w[3:0] ^ w[7:4] ^ w[11:8] ^ w[15:12], "");
        end

        // special words and neighbours under all 16 state combinations
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 24; k++) begin
                logic [15:0] w;
                if (k < 16)       w = 16'h4E40 + 16'(k);
                else if (k < 20)  w = 16'h4E70 + 16'(k - 16);
                else if (k == 20) w = 16'h4E76;
                else              w = 16'h4AF9 + 16'(k - 20);
                strobe(w, 4'(s), "");
            end
            idle_check(16'h4E70, 4'(s));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule